// File: doc/BRIEF.md
# DMA Channel Interrupt Controller

This block holds the interrupt state of a single DMA channel. Eight event lines from the channel datapath set sticky pending flags. Software sees the flags through a small 32-bit register port with word addressing. A pending flag is acknowledged by writing a one to its position. The enable mask is never written directly. Software changes it through two strobe registers: one clears mask bits and the other sets them. The mask can only be read back. One level-sensitive interrupt line is high while any pending flag is not masked.

The channel direction is a parameter, and it picks the mask value after reset. When software acknowledges a pending completion flag, the block gives a one-cycle decrement strobe. The strobe goes to the channel's completion counter, which sits outside this block. The register port has no wait states: a write takes effect at the next clock edge, and read data depends on the current address only.

Top module: `dma_irq_ctrl`

## Requirements
- R1: After reset every pending flag is 0. The mask is 0x7F when `IS_DEST`=0 (source channel) and 0xFE when `IS_DEST`=1 (destination channel).
- R2: A 1 on bit i of `ev_in` at a clock edge sets pending flag i. The flag then stays set until software clears it. Flag positions are: 7 FIFO overflow, 6 bad register access, 5 FIFO level reached, 4 memory-side timeout, 3 stream-side timeout, 2 read error, 1 completion, 0 memory-side completion.
- R3: A write to word address 5 (byte offset 0x14) clears each pending flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R4: If an event and a clear reach the same flag at the same edge, the flag is set after that edge.
- R5: A write to word address 6 (byte offset 0x18) clears each mask bit whose data bit is 1. The other mask bits are unchanged.
- R6: A write to word address 7 (byte offset 0x1C) sets each mask bit whose data bit is 1. The other mask bits are unchanged.
- R7: The mask reads at word address 8 (byte offset 0x20), and a write there has no effect. Word addresses 6 and 7 always read as 0.
- R8: `irq_o` is high exactly when some pending flag is 1 and its mask bit is 0. It follows the registered state, so it changes at the same edge as the flag or mask change.
- R9: `done_dec_o` is high, combinationally, during a cycle in which there is a write to word address 5 with data bit 1 set while completion flag 1 is pending. It is low in every other cycle. This holds even if a completion event arrives in that same cycle.
- R10: Word address 5 returns the pending flags in bits 7:0. Bits 31:8 of every read are 0. Any other address reads as 0, and write data bits 31:8 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | AW (4) | Register word address |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | DW (32) | Write data |
| reg_rdata | output | DW (32) | Read data for `reg_addr` (combinational) |
| ev_in | input | 8 | Event lines from the datapath, one-cycle pulses |
| irq_o | output | 1 | Level interrupt request |
| done_dec_o | output | 1 | Completion counter decrement strobe |

## Verification
The hardest case to reach is an event and a software clear landing on the same flag at the same edge. The completion flag is the sharpest instance: the acknowledge strobe must fire while the flag stays set. The bench reaches it with a directed cycle that drives the clear write and the event pulse together. A long phase of random writes and sparse events, compared every cycle against a behavioural model, then hits such collisions on other flags. Both channel directions are built side by side and driven by the same stimulus, so each reset mask is checked along with every path that changes it.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;
   localparam int unsigned STAT_W = 8;

   // flag positions (decoded by software)
   localparam int unsigned IDX_MEM_DONE = 0;
   localparam int unsigned IDX_DONE     = 1;
   localparam int unsigned IDX_RD_ERR   = 2;
   localparam int unsigned IDX_TO_STRM  = 3;
   localparam int unsigned IDX_TO_MEM   = 4;
   localparam int unsigned IDX_LVL_HIT  = 5;
   localparam int unsigned IDX_BAD_ACC  = 6;
   localparam int unsigned IDX_OVF      = 7;

   typedef enum logic [2:0] {
      SEL_NONE = 3'd0,
      SEL_STAT = 3'd1,
      SEL_EN   = 3'd2,
      SEL_DIS  = 3'd3,
      SEL_MASK = 3'd4
   } reg_sel_e;

   function automatic logic [STAT_W-1:0] mask_reset(input bit is_dest);
      logic [STAT_W-1:0] m;
      m = '1;
      if (is_dest) m[IDX_MEM_DONE] = 1'b0;
      else         m[IDX_OVF]      = 1'b0;
      return m;
   endfunction
endpackage

// File: rtl/dmairq_decode.sv
module dmairq_decode
   import dmairq_pkg::*;
#(
   parameter int unsigned AW       = 4,
   parameter int unsigned OFF_STAT = 32'h14,
   parameter int unsigned OFF_EN   = 32'h18,
   parameter int unsigned OFF_DIS  = 32'h1C,
   parameter int unsigned OFF_MASK = 32'h20
) (
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   output reg_sel_e      sel,
   output logic          stat_wr,
   output logic          en_wr,
   output logic          dis_wr
);
   localparam logic [AW-1:0] W_STAT = AW'(OFF_STAT >> 2);
   localparam logic [AW-1:0] W_EN   = AW'(OFF_EN   >> 2);
   localparam logic [AW-1:0] W_DIS  = AW'(OFF_DIS  >> 2);
   localparam logic [AW-1:0] W_MASK = AW'(OFF_MASK >> 2);

   always_comb begin
      sel = SEL_NONE;
      if      (reg_addr == W_STAT) sel = SEL_STAT;
      else if (reg_addr == W_EN)   sel = SEL_EN;
      else if (reg_addr == W_DIS)  sel = SEL_DIS;
      else if (reg_addr == W_MASK) sel = SEL_MASK;
   end

   assign stat_wr = reg_wr && (sel == SEL_STAT);
   assign en_wr   = reg_wr && (sel == SEL_EN);
   assign dis_wr  = reg_wr && (sel == SEL_DIS);
endmodule

// File: rtl/dmairq_status.sv
module dmairq_status #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] ev,
   input  logic [W-1:0] clr,
   output logic [W-1:0] stat_q
);
   for (genvar i = 0; i < W; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stat_q[i] <= 1'b0;
         else        stat_q[i] <= ev[i] | (stat_q[i] & ~clr[i]);
      end

      assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
         (stat_q[i] && !clr[i]) |=> stat_q[i]);
      assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && !ev[i]) |=> !stat_q[i]);
      assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
         (clr[i] && ev[i]) |=> stat_q[i]);
   end
endmodule

// File: rtl/dmairq_mask.sv
module dmairq_mask
   import dmairq_pkg::*;
#(
   parameter int unsigned W       = 8,
   parameter bit          IS_DEST = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] unmask,
   input  logic [W-1:0] domask,
   output logic [W-1:0] mask_q
);
   localparam logic [STAT_W-1:0] RST = mask_reset(IS_DEST);

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic nxt;
      always_comb begin
         nxt = mask_q[i];
         if (unmask[i]) nxt = 1'b0;
         if (domask[i]) nxt = 1'b1;
      end
      if (RST[i]) begin : g_rst1
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[i] <= 1'b1;
            else        mask_q[i] <= nxt;
         end
      end else begin : g_rst0
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mask_q[i] <= 1'b0;
            else        mask_q[i] <= nxt;
         end
      end

      assert_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
         (unmask[i] && !domask[i]) |=> !mask_q[i]);
      assert_disable_R6: assert property (@(posedge clk) disable iff (!rst_n)
         domask[i] |=> mask_q[i]);
   end

   assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (unmask == '0 && domask == '0) |=> $stable(mask_q));
endmodule

// File: rtl/dma_irq_ctrl.sv
module dma_irq_ctrl
   import dmairq_pkg::*;
#(
   parameter bit          IS_DEST  = 1'b0,
   parameter int unsigned DW       = 32,
   parameter int unsigned AW       = 4,
   parameter int unsigned OFF_STAT = 32'h14,
   parameter int unsigned OFF_EN   = 32'h18,
   parameter int unsigned OFF_DIS  = 32'h1C,
   parameter int unsigned OFF_MASK = 32'h20
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     reg_addr,
   input  logic              reg_wr,
   input  logic [DW-1:0]     reg_wdata,
   output logic [DW-1:0]     reg_rdata,
   input  logic [STAT_W-1:0] ev_in,
   output logic              irq_o,
   output logic              done_dec_o
);
   if (DW < STAT_W) begin : g_bad_dw
      $error("dma_irq_ctrl: DW must hold all flags");
   end
   if (((OFF_STAT | OFF_EN | OFF_DIS | OFF_MASK) & 3) != 0) begin : g_bad_align
      $error("dma_irq_ctrl: offsets must be word aligned");
   end
   if ((OFF_MASK >> 2) >= (1 << AW) || (OFF_DIS >> 2) >= (1 << AW) ||
       (OFF_EN >> 2) >= (1 << AW) || (OFF_STAT >> 2) >= (1 << AW)) begin : g_bad_aw
      $error("dma_irq_ctrl: AW too narrow for offsets");
   end

   reg_sel_e          sel;
   logic              stat_wr, en_wr, dis_wr;
   logic [STAT_W-1:0] wlo, stat_q, mask_q;
   logic [STAT_W-1:0] clr_bits, en_bits, dis_bits;
   logic              unused_hi;

   assign wlo       = reg_wdata[STAT_W-1:0];
   assign unused_hi = ^reg_wdata;

   dmairq_decode #(
      .AW(AW), .OFF_STAT(OFF_STAT), .OFF_EN(OFF_EN),
      .OFF_DIS(OFF_DIS), .OFF_MASK(OFF_MASK)
   ) u_dec (
      .reg_addr(reg_addr), .reg_wr(reg_wr), .sel(sel),
      .stat_wr(stat_wr), .en_wr(en_wr), .dis_wr(dis_wr)
   );

   assign clr_bits = stat_wr ? wlo : '0;
   assign en_bits  = en_wr   ? wlo : '0;
   assign dis_bits = dis_wr  ? wlo : '0;

   dmairq_status #(.W(STAT_W)) u_stat (
      .clk(clk), .rst_n(rst_n), .ev(ev_in), .clr(clr_bits), .stat_q(stat_q)
   );

   dmairq_mask #(.W(STAT_W), .IS_DEST(IS_DEST)) u_mask (
      .clk(clk), .rst_n(rst_n), .unmask(en_bits), .domask(dis_bits), .mask_q(mask_q)
   );

   assign irq_o      = |(stat_q & ~mask_q);
   assign done_dec_o = stat_wr & wlo[IDX_DONE] & stat_q[IDX_DONE];

   always_comb begin
      reg_rdata = '0;
      case (sel)
         SEL_STAT: reg_rdata[STAT_W-1:0] = stat_q;
         SEL_MASK: reg_rdata[STAT_W-1:0] = mask_q;
         default:  reg_rdata = '0;
      endcase
   end

   assert_dec_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done_dec_o && !ev_in[IDX_DONE]) |=> !stat_q[IDX_DONE]);
   assert_irq_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> ($past(ev_in) != '0 || $past(en_wr)));
endmodule

// File: tb/dma_irq_ctrl_bench.sv
module dma_irq_ctrl_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [7:0]  ev_in = '0;
   logic [31:0] rd_s, rd_d;
   logic        irq_s, irq_d, dec_s, dec_d;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   // reference state
   logic [7:0] m_stat;
   logic [7:0] m_mask_s, m_mask_d;

   // sampled outputs of the last step
   logic [31:0] c_rd_s, c_rd_d;
   logic        c_irq_s, c_irq_d, c_dec_s, c_dec_d;

   always #5 clk = ~clk;

   dma_irq_ctrl #(.IS_DEST(1'b0)) u_dma_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_s), .ev_in(ev_in),
      .irq_o(irq_s), .done_dec_o(dec_s)
   );

   dma_irq_ctrl #(.IS_DEST(1'b1)) u_dma_irq_ctrl_dst (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(rd_d), .ev_in(ev_in),
      .irq_o(irq_d), .done_dec_o(dec_d)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_rd(input logic [3:0] a, input logic [7:0] mk);
      if (a == 4'd5) return {24'h0, m_stat};
      if (a == 4'd8) return {24'h0, mk};
      return 32'h0;
   endfunction

   // one clock: drive at negedge, compare, then advance the model at posedge
   task automatic step(input logic [3:0] a, input logic w, input logic [31:0] d,
                       input logic [7:0] e);
      logic dec_exp;
      reg_addr = a; reg_wr = w; reg_wdata = d; ev_in = e;
      #1;
      c_rd_s = rd_s; c_rd_d = rd_d; c_irq_s = irq_s; c_irq_d = irq_d;
      c_dec_s = dec_s; c_dec_d = dec_d;
      dec_exp = w && (a == 4'd5) && d[1] && m_stat[1];
      chk("R10 rdata src", rd_s, exp_rd(a, m_mask_s));
      chk("R10 rdata dst", rd_d, exp_rd(a, m_mask_d));
      chk("R8 irq src", {31'h0, irq_s}, {31'h0, |(m_stat & ~m_mask_s)});
      chk("R8 irq dst", {31'h0, irq_d}, {31'h0, |(m_stat & ~m_mask_d)});
      chk("R9 dec src", {31'h0, dec_s}, {31'h0, dec_exp});
      chk("R9 dec dst", {31'h0, dec_d}, {31'h0, dec_exp});
      @(posedge clk);
      if (w && a == 4'd5) m_stat = e | (m_stat & ~d[7:0]);
      else                m_stat = e | m_stat;
      if (w && a == 4'd6) begin m_mask_s &= ~d[7:0]; m_mask_d &= ~d[7:0]; end
      if (w && a == 4'd7) begin m_mask_s |= d[7:0];  m_mask_d |= d[7:0];  end
      @(negedge clk);
   endtask

   task automatic idle(input logic [3:0] a);
      step(a, 1'b0, 32'h0, 8'h0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog act=hung exp=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      m_stat = 8'h00; m_mask_s = 8'h7F; m_mask_d = 8'hFE;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      idle(4'd5);
      chk("R1 status", c_rd_s, 32'h0);
      idle(4'd8);
      chk("R1 mask src", c_rd_s, 32'h7F);
      chk("R1 mask dst", c_rd_d, 32'hFE);
      chk("R1 irq", {30'h0, c_irq_s, c_irq_d}, 32'h0);

      // R2 events are sticky
      step(4'd0, 1'b0, 32'h0, 8'h05);
      idle(4'd0); idle(4'd0);
      idle(4'd5);
      chk("R2 sticky", c_rd_s, 32'h05);
      chk("R8 masked src", {31'h0, c_irq_s}, 32'h0);
      chk("R8 dst mem-done open", {31'h0, c_irq_d}, 32'h1);

      // R5 enable clears mask bits
      step(4'd6, 1'b1, 32'h04, 8'h0);
      idle(4'd8);
      chk("R5 mask src", c_rd_s, 32'h7B);
      chk("R8 irq after enable", {31'h0, c_irq_s}, 32'h1);
      idle(4'd6);
      chk("R7 enable reads 0", c_rd_s, 32'h0);

      // R3 write-one-to-clear
      step(4'd5, 1'b1, 32'h04, 8'h0);
      idle(4'd5);
      chk("R3 w1c", c_rd_s, 32'h01);
      chk("R8 irq dropped", {31'h0, c_irq_s}, 32'h0);

      // R6 disable sets mask bits
      step(4'd7, 1'b1, 32'h84, 8'h0);
      idle(4'd8);
      chk("R6 mask src", c_rd_s, 32'hFF);
      chk("R6 mask dst", c_rd_d, 32'hFE);
      idle(4'd7);
      chk("R7 disable reads 0", c_rd_s, 32'h0);

      // R7 mask not writable
      step(4'd8, 1'b1, 32'h0, 8'h0);
      idle(4'd8);
      chk("R7 mask held", c_rd_s, 32'hFF);

      // R9 acknowledge of pending completion
      step(4'd0, 1'b0, 32'h0, 8'h02);
      step(4'd5, 1'b1, 32'h02, 8'h0);
      chk("R9 dec on ack", {31'h0, c_dec_s}, 32'h1);
      step(4'd5, 1'b1, 32'h02, 8'h0);
      chk("R9 no dec when clear", {31'h0, c_dec_s}, 32'h0);

      // R4 event beats clear (completion flag: strobe still fires)
      step(4'd0, 1'b0, 32'h0, 8'h0A);
      step(4'd5, 1'b1, 32'h0A, 8'h0A);
      chk("R9 dec with collision", {31'h0, c_dec_s}, 32'h1);
      idle(4'd5);
      chk("R4 event wins", c_rd_s, 32'h0B);

      // R10 upper data ignored, upper read zero, unmapped zero
      step(4'd5, 1'b1, 32'hFFFF_FF00, 8'h0);
      idle(4'd5);
      chk("R10 upper write ignored", c_rd_s, 32'h0B);
      idle(4'd3);
      chk("R10 unmapped", c_rd_s, 32'h0);

      // random phase, model compared every cycle
      for (int i = 0; i < 400; i++) begin
         logic [3:0] a;
         logic [7:0] e;
         a = 4'(4 + $urandom_range(0, 5));
         e = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0;
         step(a, 1'($urandom_range(0, 1)), $urandom, e);
      end

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule